// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side controller of a byte-wide NOR flash model. It watches write strobes on a synchronous bus of address, write data and a write/read select. It recognises the unlock-prefixed command sequences for byte program, sector erase and whole-array erase, and runs each embedded operation for a fixed number of clock cycles. The storage is a small behavioural array: each sector keeps only a few bytes, selected by the lowest address bits, so that a full-width address can be exercised without a full-size memory.

While an operation is running, reads that fall on the affected storage return a status byte instead of array data. In that byte, bit 7 is inverted with respect to the final data and bit 6 flips on every status read. During a sector erase, reads and byte programs that target sectors outside the erase set still work. Several sectors can be collected into one erase while a short acceptance window is open. An active-low reset abandons any partial sequence and any running operation.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A program sequence (AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then data D at target address T) replaces the byte at T with (old AND D) once the operation ends; a later read of T returns that value.
- R2: The erase prefix (AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh) followed by 30h written to an address in sector S sets every byte of S to FFh. Bytes in other sectors keep their values.
- R3: The erase prefix followed by 10h written to 5555h sets every byte of every sector to FFh.
- R4: A write whose address or data does not match the step the sequence has reached returns the decoder to idle with no change to the array. A correct sequence issued afterwards is accepted normally.
- R5: While a program is running, every read returns a status byte with bit 7 equal to the inverse of bit 7 of D and bits 5..0 zero. While an erase is running, a read in an erasing sector returns bit 7 = 0 and bits 5..0 zero.
- R6: Status bit 6 reads 0 on the first status read of an operation and flips on every following status read. Once the operation ends, reads return array data.
- R7: During a sector erase, a read of a sector outside the erase set returns its array data. A program sequence aimed at such a sector takes effect at once, while busy stays high.
- R8: After the first 30h, each further write of 30h within WIN_CYC cycles of the previous one adds that address's sector to the erase set and restarts the window. Writes with other data during the window are ignored. The erase starts when the window lapses.
- R9: Driving rst_n low drops busy, discards a running operation (the array keeps its values) and forgets any partial sequence.
- R10: Command addresses are compared on bus_addr[14:0] only. The sector is bus_addr[ADDR_W-1 -: SEC_W], and the byte within the behavioural sector is bus_addr[OFF_W-1:0]. All other address bits are ignored.
- R11: busy rises at the clock edge that takes the last write of a program sequence and stays high for exactly PROG_CYC cycles. A read issued in cycle k returns bus_rdata with rd_valid high in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus strobe, one access per cycle in which it is high |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or status byte, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| busy | output | 1 | An embedded program or erase (including the erase window) is active |

## Verification
Several properties are checked on every cycle. The decoder can only reach its data and final-erase steps from the step before them. The erase set is never empty while an erase is pending and is frozen while the erase runs. A program stays busy for exactly PROG_CYC cycles. Status reads during a program carry the inverted data bit 7, and reads of sectors outside the erase set return array data during an erase. Whole-sequence effects cannot be checked by a local property and are shown only by the bench's scenarios: bitwise AND programming, erase of the collected sectors, recovery from a malformed sequence, exact toggle values, and the state of the array after a reset abort.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  K_AA     = 8'hAA;
  localparam logic [7:0]  K_55     = 8'h55;
  localparam logic [7:0]  K_PROG   = 8'hA0;
  localparam logic [7:0]  K_ERASE  = 8'h80;
  localparam logic [7:0]  K_SECT   = 8'h30;
  localparam logic [7:0]  K_CHIP   = 8'h10;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PDATA, SQ_EKEY0, SQ_EKEY1, SQ_EKEY2
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_GATHER, OP_ERASE
  } op_st_e;
endpackage

// File: rtl/flash_seq_dec.sv
module flash_seq_dec
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [14:0] wr_lo,
  input  logic [7:0]  wr_data,
  output logic        prog_req,
  output logic        sect_req,
  output logic        chip_req,
  output seq_st_e     st_o
);
  seq_st_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (wr_lo == UNLOCK_A);
  assign at_b = (wr_lo == UNLOCK_B);

  always_comb begin
    st_d     = st_q;
    prog_req = 1'b0;
    sect_req = 1'b0;
    chip_req = 1'b0;
    if (wr_en) begin
      case (st_q)
        SQ_IDLE:  st_d = (at_a && wr_data == K_AA) ? SQ_KEY1 : SQ_IDLE;
        SQ_KEY1:  st_d = (at_b && wr_data == K_55) ? SQ_KEY2 : SQ_IDLE;
        SQ_KEY2: begin
          if (at_a && wr_data == K_PROG)       st_d = SQ_PDATA;
          else if (at_a && wr_data == K_ERASE) st_d = SQ_EKEY0;
          else                                 st_d = SQ_IDLE;
        end
        SQ_PDATA: begin
          prog_req = 1'b1;
          st_d     = SQ_IDLE;
        end
        SQ_EKEY0: st_d = (at_a && wr_data == K_AA) ? SQ_EKEY1 : SQ_IDLE;
        SQ_EKEY1: st_d = (at_b && wr_data == K_55) ? SQ_EKEY2 : SQ_IDLE;
        SQ_EKEY2: begin
          sect_req = (wr_data == K_SECT);
          chip_req = (wr_data == K_CHIP) && at_a;
          st_d     = SQ_IDLE;
        end
        default:  st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SQ_IDLE;
    else if (wr_en) st_q <= st_d;
  end

  assign st_o = st_q;

  // R1: the data step is reachable only from the program key step
  p_pdata_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_PDATA) |-> ($past(st_q) == SQ_KEY2 || $past(st_q) == SQ_PDATA));

  // R4: the final erase step needs the full second unlock before it
  p_ekey2_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_EKEY2) |-> ($past(st_q) == SQ_EKEY1 || $past(st_q) == SQ_EKEY2));
endmodule

// File: rtl/flash_op_ctl.sv
module flash_op_ctl
  import flash_cmd_pkg::*;
#(
  parameter int SEC_W     = 5,
  parameter int OFF_W     = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     raw_wr,
  input  logic [SEC_W-1:0]         wr_sec,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [7:0]               wr_data,
  input  logic                     prog_req,
  input  logic                     sect_req,
  input  logic                     chip_req,
  output op_st_e                   op,
  output logic [(1<<SEC_W)-1:0]    mask,
  output logic [SEC_W-1:0]         tgt_sec,
  output logic [OFF_W-1:0]         tgt_off,
  output logic [7:0]               tgt_data,
  output logic                     fin_prog,
  output logic                     fin_erase,
  output logic                     now_prog
);
  localparam int NSECT = 1 << SEC_W;
  localparam int MAXA  = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int MAXC  = (ERASE_CYC > MAXA) ? ERASE_CYC : MAXA;
  localparam int CNT_W = $clog2(MAXC + 1);

  op_st_e            op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NSECT-1:0]  mask_q, mask_d, sec_bit;
  logic              load_tgt;

  assign sec_bit = NSECT'(1) << wr_sec;

  always_comb begin
    op_d      = op_q;
    cnt_d     = cnt_q;
    mask_d    = mask_q;
    load_tgt  = 1'b0;
    fin_prog  = 1'b0;
    fin_erase = 1'b0;
    now_prog  = 1'b0;
    case (op_q)
      OP_NONE: begin
        if (prog_req) begin
          op_d     = OP_PROG;
          cnt_d    = CNT_W'(PROG_CYC - 1);
          load_tgt = 1'b1;
        end else if (sect_req) begin
          op_d   = OP_GATHER;
          mask_d = sec_bit;
          cnt_d  = CNT_W'(WIN_CYC - 1);
        end else if (chip_req) begin
          op_d   = OP_ERASE;
          mask_d = '1;
          cnt_d  = CNT_W'(ERASE_CYC - 1);
        end
      end
      OP_PROG: begin
        if (cnt_q == '0) begin
          fin_prog = 1'b1;
          op_d     = OP_NONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_GATHER: begin
        if (raw_wr && wr_data == K_SECT) begin
          mask_d = mask_q | sec_bit;
          cnt_d  = CNT_W'(WIN_CYC - 1);
        end else if (cnt_q == '0) begin
          op_d  = OP_ERASE;
          cnt_d = CNT_W'(ERASE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_ERASE: begin
        now_prog = prog_req && !mask_q[wr_sec];
        if (cnt_q == '0) begin
          fin_erase = 1'b1;
          op_d      = OP_NONE;
          mask_d    = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: op_d = OP_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_sec  <= '0;
      tgt_off  <= '0;
      tgt_data <= '0;
    end else if (load_tgt) begin
      tgt_sec  <= wr_sec;
      tgt_off  <= wr_off;
      tgt_data <= wr_data;
    end
  end

  assign op   = op_q;
  assign mask = mask_q;

  // checker: length of the current program run
  logic [CNT_W-1:0] chk_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_len_q <= '0;
    else if (op_q != OP_PROG)  chk_len_q <= '0;
    else                       chk_len_q <= chk_len_q + 1'b1;
  end

  // R11: a program completes after exactly PROG_CYC busy cycles
  p_prog_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin_prog |-> (chk_len_q == CNT_W'(PROG_CYC - 1)));

  // R2: a pending or running erase always has a sector to erase
  p_mask_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_GATHER || op_q == OP_ERASE) |-> (mask_q != '0));

  // R8: the erase set is closed once the erase itself runs
  p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_ERASE && $past(op_q) == OP_ERASE) |-> $stable(mask_q));
endmodule

// File: rtl/flash_arr.sv
module flash_arr #(
  parameter int SEC_W = 5,
  parameter int OFF_W = 2
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [SEC_W-1:0]       wr_sec,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [7:0]             wr_data,
  input  logic                   er_en,
  input  logic [(1<<SEC_W)-1:0]  er_mask,
  input  logic [SEC_W-1:0]       rd_sec,
  input  logic [OFF_W-1:0]       rd_off,
  output logic [7:0]             rd_q
);
  localparam int NSECT = 1 << SEC_W;
  localparam int NOFF  = 1 << OFF_W;

  logic [7:0] rd_bank [NSECT];

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    logic [7:0] bank [NOFF];
    logic       hit_wr;

    assign hit_wr = wr_en && (wr_sec == SEC_W'(g));

    always_ff @(posedge clk) begin
      if (er_en && er_mask[g]) begin
        for (int o = 0; o < NOFF; o++) bank[o] <= 8'hFF;
      end else if (hit_wr) begin
        bank[wr_off] <= bank[wr_off] & wr_data;
      end
    end

    assign rd_bank[g] = bank[rd_off];
  end

  assign rd_q = rd_bank[rd_sec];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int SEC_W     = 5,
  parameter int OFF_W     = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rd_valid,
  output logic              busy
);
  localparam int NSECT = 1 << SEC_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic             wr, rd, dec_wr;
  logic [SEC_W-1:0] a_sec;
  logic [OFF_W-1:0] a_off;
  logic             addr_unused;

  assign wr          = bus_en && bus_we;
  assign rd          = bus_en && !bus_we;
  assign a_sec       = bus_addr[ADDR_W-1 -: SEC_W];
  assign a_off       = bus_addr[OFF_W-1:0];
  assign addr_unused = ^bus_addr;

  op_st_e           op;
  logic [NSECT-1:0] mask;
  logic [SEC_W-1:0] tgt_sec;
  logic [OFF_W-1:0] tgt_off;
  logic [7:0]       tgt_data;
  logic             fin_prog, fin_erase, now_prog;
  logic             prog_req, sect_req, chip_req;
  seq_st_e          dec_st;

  assign dec_wr = wr && (op == OP_NONE || op == OP_ERASE);

  flash_seq_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (dec_wr),
    .wr_lo    (bus_addr[14:0]),
    .wr_data  (bus_wdata),
    .prog_req (prog_req),
    .sect_req (sect_req),
    .chip_req (chip_req),
    .st_o     (dec_st)
  );

  flash_op_ctl #(
    .SEC_W     (SEC_W),
    .OFF_W     (OFF_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .WIN_CYC   (WIN_CYC)
  ) u_op (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .raw_wr    (wr),
    .wr_sec    (a_sec),
    .wr_off    (a_off),
    .wr_data   (bus_wdata),
    .prog_req  (prog_req),
    .sect_req  (sect_req),
    .chip_req  (chip_req),
    .op        (op),
    .mask      (mask),
    .tgt_sec   (tgt_sec),
    .tgt_off   (tgt_off),
    .tgt_data  (tgt_data),
    .fin_prog  (fin_prog),
    .fin_erase (fin_erase),
    .now_prog  (now_prog)
  );

  logic             arr_we;
  logic [SEC_W-1:0] arr_sec;
  logic [OFF_W-1:0] arr_off;
  logic [7:0]       arr_wd, arr_q;

  assign arr_we  = fin_prog || now_prog;
  assign arr_sec = fin_prog ? tgt_sec  : a_sec;
  assign arr_off = fin_prog ? tgt_off  : a_off;
  assign arr_wd  = fin_prog ? tgt_data : bus_wdata;

  flash_arr #(.SEC_W(SEC_W), .OFF_W(OFF_W)) u_arr (
    .clk     (clk),
    .wr_en   (arr_we),
    .wr_sec  (arr_sec),
    .wr_off  (arr_off),
    .wr_data (arr_wd),
    .er_en   (fin_erase),
    .er_mask (mask),
    .rd_sec  (a_sec),
    .rd_off  (a_off),
    .rd_q    (arr_q)
  );

  // read path: status while the addressed storage is busy
  logic       stat_hit, tgl_q, tgl_d;
  logic [7:0] stat_byte, rdata_d;

  assign stat_hit  = (op == OP_PROG) ||
                     ((op == OP_GATHER || op == OP_ERASE) && mask[a_sec]);
  assign stat_byte = {~((op == OP_PROG) ? tgt_data[7] : 1'b1), tgl_q, 6'b0};

  always_comb begin
    rdata_d = stat_hit ? stat_byte : arr_q;
    tgl_d   = tgl_q;
    if (op == OP_NONE)      tgl_d = 1'b0;
    else if (rd && stat_hit) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
      tgl_q     <= 1'b0;
    end else begin
      rd_valid <= rd;
      tgl_q    <= tgl_d;
      if (rd) bus_rdata <= rdata_d;
    end
  end

  assign busy = (op != OP_NONE);

  // R5: status reads during a program carry the inverted data bit 7
  p_prog_bit7_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd && op == OP_PROG) |=> (bus_rdata[7] == !$past(tgt_data[7])));

  // R7: sectors outside the erase set read as array data during erase
  p_free_sector_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd && op == OP_ERASE && !mask[a_sec]) |=> (bus_rdata == $past(arr_q)));

  // R1: no new command decode may start while a program runs
  p_dec_quiet_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_PROG) |-> (dec_st == SQ_IDLE));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic          rd_valid, busy;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(
    .ADDR_W(AW), .SEC_W(5), .OFF_W(2),
    .PROG_CYC(12), .ERASE_CYC(30), .WIN_CYC(6)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_valid(rd_valid), .busy(busy)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [AW-1:0] ad(input logic [4:0] s, input logic [1:0] o);
    return {s, 14'd0, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each returned read with the scoreboard head
  always @(negedge clk) begin
    if (rd_valid === 1'b1 && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected read return", bus_rdata, 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bwr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic prog_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAA, 8'h55);
    bwr(21'h05555, 8'hA0);
    bwr(a, d);
  endtask

  task automatic erase_prefix();
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAA, 8'h55);
    bwr(21'h05555, 8'h80);
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAA, 8'h55);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(rd_valid == 1'b0, "R11 rd_valid after reset", rd_valid, 0);

    // R3 chip erase, with erase status reads (R5, R6)
    erase_prefix();
    bwr(21'h05555, 8'h10);
    chk(busy == 1'b1, "R3 busy during chip erase", busy, 1);
    brd(ad(5'd0, 2'd0), 8'h00, "R5 erase status first read");
    brd(ad(5'd3, 2'd1), 8'h40, "R6 erase status toggled");
    wait_idle();
    brd(ad(5'd0, 2'd0), 8'hFF, "R3 sector 0 erased");
    brd(ad(5'd31, 2'd3), 8'hFF, "R3 sector 31 erased");
    brd(ad(5'd7, 2'd1), 8'hFF, "R3 sector 7 erased");

    // R1 program with status reads (R5, R6)
    prog_cmd(ad(5'd1, 2'd2), 8'h5A);
    brd(ad(5'd1, 2'd2), 8'h80, "R5 program status bit7 inverted");
    brd(ad(5'd9, 2'd0), 8'hC0, "R6 program status toggle 1");
    brd(ad(5'd1, 2'd2), 8'h80, "R6 program status toggle 0");
    wait_idle();
    brd(ad(5'd1, 2'd2), 8'h5A, "R6 true data after program");
    prog_cmd(ad(5'd1, 2'd2), 8'h0F);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == 12, "R11 program busy length", n, 12);
    brd(ad(5'd1, 2'd2), 8'h0A, "R1 program ANDs old data");

    // R4 malformed sequences leave the array alone
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAB, 8'h55);
    bwr(21'h05555, 8'hA0);
    bwr(ad(5'd4, 2'd0), 8'h00);
    chk(busy == 1'b0, "R4 no busy after bad address", busy, 0);
    brd(ad(5'd4, 2'd0), 8'hFF, "R4 bad address ignored");
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAA, 8'h55);
    bwr(21'h05555, 8'h77);
    bwr(ad(5'd4, 2'd0), 8'h00);
    brd(ad(5'd4, 2'd0), 8'hFF, "R4 bad command ignored");
    prog_cmd(ad(5'd4, 2'd0), 8'h3C);
    wait_idle();
    brd(ad(5'd4, 2'd0), 8'h3C, "R4 recovery then program");

    // R10 unlock compared on low bits, offset aliasing
    bwr(21'h1D555, 8'hAA);
    bwr(21'h0AAAA, 8'h55);
    bwr(21'h15555, 8'hA0);
    bwr(ad(5'd5, 2'd2), 8'h96);
    wait_idle();
    brd(21'h5FFFE, 8'h96, "R10 aliased read of program");

    // R2, R7, R8 sector erase with window
    prog_cmd(ad(5'd6, 2'd1), 8'h11);
    wait_idle();
    prog_cmd(ad(5'd9, 2'd3), 8'h22);
    wait_idle();
    erase_prefix();
    bwr(ad(5'd1, 2'd0), 8'h30);
    bwr(ad(5'd9, 2'd3), 8'h55);
    bwr(ad(5'd6, 2'd0), 8'h30);
    brd(ad(5'd4, 2'd0), 8'h3C, "R7 free sector read in window");
    brd(ad(5'd1, 2'd2), 8'h00, "R5 erasing sector status");
    repeat (10) @(negedge clk);
    prog_cmd(ad(5'd4, 2'd1), 8'h77);
    brd(ad(5'd4, 2'd1), 8'h77, "R7 program during erase");
    chk(busy == 1'b1, "R7 erase still busy", busy, 1);
    brd(ad(5'd6, 2'd1), 8'h40, "R8 added sector shows status");
    wait_idle();
    brd(ad(5'd1, 2'd2), 8'hFF, "R2 sector 1 erased");
    brd(ad(5'd6, 2'd1), 8'hFF, "R8 sector 6 erased");
    brd(ad(5'd9, 2'd3), 8'h22, "R8 non-30h write ignored");
    brd(ad(5'd4, 2'd0), 8'h3C, "R2 other sector kept");

    // R9 reset aborts an erase and a partial sequence
    prog_cmd(ad(5'd2, 2'd0), 8'h00);
    wait_idle();
    erase_prefix();
    bwr(ad(5'd2, 2'd0), 8'h30);
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9 busy cleared by reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    brd(ad(5'd2, 2'd0), 8'h00, "R9 aborted erase left data");
    bwr(21'h05555, 8'hAA);
    bwr(21'h02AAA, 8'h55);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bwr(21'h05555, 8'hA0);
    bwr(ad(5'd3, 2'd0), 8'h00);
    chk(busy == 1'b0, "R9 partial sequence forgotten", busy, 0);
    brd(ad(5'd3, 2'd0), 8'hFF, "R9 no program after reset");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule